// File: doc/BRIEF.md
# Strided Vector Address Generator

This block produces the stream of memory element addresses for a vector load or store. A command gives a start address, a signed stride and a total element count. The generator then issues one request per clock while the consumer is ready. Each request splits the word address into a bank number and an address within that bank, for a low-order interleaved memory.

A vector longer than the register length is cut into register-sized pieces. The short piece that holds the leftover elements is issued first, and full-length pieces follow it. Every request carries the length of the piece it belongs to, ready to load into the vector length register. A done pulse marks the end of the whole vector. A vector of zero length completes at once.

Top module: `vec_agen`

## Requirements
- R1: After a synchronous active-low reset, `req_valid`, `done` and `busy` are all 0.
- R2: The first request of a command carries the command base address. `req_bank` is the low `BANK_W` bits (default 6, so 64 banks) of the word address, and `req_row` is the remaining high bits.
- R3: Each accepted request is followed by the address of the previous request plus the stride. The stride is two's complement, so it may be negative or zero, and the sum wraps modulo 2^`ADDR_W`.
- R4: Piece lengths follow this order. If the total length mod `MAX_VL` (default 64) is nonzero, a piece of that many elements comes first. All later pieces are `MAX_VL` long. An exact multiple of `MAX_VL` has no short piece.
- R5: `req_vl` gives the length of the piece the current request belongs to. It is between 1 and `MAX_VL`, and it does not change within a piece.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_bank`, `req_row` and `req_vl` hold their values into the next cycle.
- R7: With `req_ready` held high, a request is accepted every cycle from the first element to the last, including across piece boundaries.
- R8: Exactly as many requests are accepted as the total length. `done` is high for one cycle, the cycle after the last request is accepted, and `req_valid` is low in that cycle.
- R9: A command with a total length of zero issues no request and raises `done` in the cycle after it is accepted.
- R10: A command presented while `busy` is high is ignored, and the running address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a vector; taken only when not busy |
| cmd_base | input | ADDR_W (32) | First element word address |
| cmd_stride | input | ADDR_W (32) | Signed element-to-element distance |
| cmd_len | input | LEN_W (16) | Total element count |
| busy | output | 1 | A vector is being issued |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_bank | output | BANK_W (6) | Interleaved bank number |
| req_row | output | ADDR_W-BANK_W (26) | Address within the bank |
| req_vl | output | VL_W (7) | Length of the current piece |
| done | output | 1 | One-cycle end-of-vector pulse |

## Verification
A corrupted address accumulator shows up on the very next accepted request, as a bank or row that differs from base plus element index times stride. A wrong piece counter shows up instead as a wrong `req_vl` at the first element of the affected piece, or as `done` arriving early or late against the total length. A stuck state bit shows up within a cycle: `req_valid` drops mid-vector, or a request appears after `done`. Stall cycles expose any register that advances without a handshake, because the held outputs change before `req_ready` returns.

// File: rtl/vec_agen_pkg.sv
// Shared types for the strided vector address generator.
package vec_agen_pkg;
    // Sequencer state: waiting for a command, or issuing elements.
    typedef enum logic {
        AG_IDLE = 1'b0,
        AG_RUN  = 1'b1
    } ag_state_t;
endpackage

// File: rtl/vec_agen_strip.sv
// Piece sequencer: tracks elements left in the whole vector and in the
// current piece. Issues the short leftover piece first, then full pieces.
// Assumes MAX_VL is a power of two and that load and step never coincide.
module vec_agen_strip #(
    parameter int LEN_W  = 16,
    parameter int MAX_VL = 64,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int REM_W = $clog2(MAX_VL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] total_len,
    input  logic             step,
    output logic [VL_W-1:0]  piece_vl,
    output logic             last_elem
);
    localparam logic [VL_W-1:0] FULL = VL_W'(MAX_VL);

    logic [LEN_W-1:0] left_total;
    logic [VL_W-1:0]  left_piece;
    logic [VL_W-1:0]  vl_q;
    logic [REM_W-1:0] rem;
    logic [VL_W-1:0]  first_vl;

    // Length of the first piece: the leftover, or a full piece if none.
    always_comb begin
        rem      = total_len[REM_W-1:0];
        first_vl = (rem == '0) ? FULL : VL_W'(rem);
    end

    // Counts down the vector and piece totals on each accepted element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_total <= '0;
            left_piece <= '0;
            vl_q       <= '0;
        end else if (load) begin
            left_total <= total_len;
            left_piece <= first_vl;
            vl_q       <= first_vl;
        end else if (step) begin
            left_total <= left_total - 1'b1;
            if (left_piece == VL_W'(1)) begin
                left_piece <= FULL;
                vl_q       <= FULL;
            end else begin
                left_piece <= left_piece - 1'b1;
            end
        end
    end

    assign piece_vl  = vl_q;
    assign last_elem = (left_total == LEN_W'(1));

    // R10: without a load or step, the remaining count stays put.
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(left_total));
    // R5: piece length changes only at a piece boundary.
    a_r5_vl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (step && left_piece != VL_W'(1)) |=> $stable(vl_q));
endmodule

// File: rtl/vec_agen_addr.sv
// Address accumulator: holds the current element address and the stride.
// Each step adds the signed stride, wrapping modulo 2^ADDR_W. The output
// is split into a low-order bank index and an in-bank row.
module vec_agen_addr #(
    parameter int ADDR_W = 32,
    parameter int BANK_W = 6,
    localparam int ROW_W = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic              step,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [ADDR_W-1:0] stride_held
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    // Loads the start address and stride, then advances one stride per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
        end else if (step) begin
            addr_q <= addr_q + stride_q;
        end
    end

    assign bank        = addr_q[BANK_W-1:0];
    assign row         = addr_q[ADDR_W-1:BANK_W];
    assign stride_held = stride_q;

    // R6: the address does not move without a step or load.
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(addr_q));
endmodule

// File: rtl/vec_agen.sv
// Strided vector address generator top. Accepts a command when idle, then
// issues one bank/row request per accepted handshake. The piece length
// rides along with every request. A one-cycle done pulse follows the last
// element. Commands arriving while busy are dropped.
module vec_agen #(
    parameter int ADDR_W = 32,
    parameter int BANK_W = 6,
    parameter int LEN_W  = 16,
    parameter int MAX_VL = 64,
    localparam int ROW_W = ADDR_W - BANK_W,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [BANK_W-1:0] req_bank,
    output logic [ROW_W-1:0]  req_row,
    output logic [VL_W-1:0]   req_vl,
    output logic              done
);
    import vec_agen_pkg::*;

    ag_state_t         state;
    logic              accept;
    logic              start_run;
    logic              fire;
    logic              last_elem;
    logic              done_q;
    logic [ADDR_W-1:0] stride_held;

    // Handshake decode for command intake and request issue.
    always_comb begin
        accept    = cmd_valid && (state == AG_IDLE);
        start_run = accept && (cmd_len != '0);
        fire      = (state == AG_RUN) && req_ready;
    end

    // Moves between idle and issuing; raises done after the final element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= AG_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= (accept && cmd_len == '0) || (fire && last_elem);
            if (start_run)
                state <= AG_RUN;
            else if (fire && last_elem)
                state <= AG_IDLE;
        end
    end

    vec_agen_strip #(.LEN_W(LEN_W), .MAX_VL(MAX_VL)) u_strip (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_run),
        .total_len (cmd_len),
        .step      (fire),
        .piece_vl  (req_vl),
        .last_elem (last_elem)
    );

    vec_agen_addr #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start_run),
        .base        (cmd_base),
        .stride      (cmd_stride),
        .step        (fire),
        .bank        (req_bank),
        .row         (req_row),
        .stride_held (stride_held)
    );

    assign busy      = (state == AG_RUN);
    assign req_valid = (state == AG_RUN);
    assign done      = done_q;

    // R3: the next address is the accepted one plus the held stride.
    a_r3_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_elem) |=>
        ({req_row, req_bank} == $past({req_row, req_bank}) + $past(stride_held)));
    // R6: a stalled request keeps its contents.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable(req_bank) && $stable(req_row) && $stable(req_vl)));
    // R7: no gap between elements while the vector is unfinished.
    a_r7_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_elem) |=> req_valid);
    // R8: done never overlaps a pending request.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
    // R9: a zero-length command finishes on the next cycle with nothing issued.
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_len == '0) |=> (done && !req_valid));
    // R5: piece length is always in range while issuing.
    a_r5_vl_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_vl != '0 && req_vl <= VL_W'(MAX_VL)));
endmodule

// File: tb/vec_agen_bench.sv
module vec_agen_bench;
    localparam int ADDR_W = 32;
    localparam int BANK_W = 6;
    localparam int LEN_W  = 16;
    localparam int MAX_VL = 64;
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int NV     = 7;

    // Stimulus table: base, stride, length, ready mode (1 = stalls), busy injection.
    localparam logic [31:0] T_BASE [NV] = '{32'h100, 32'h1000, 32'h40, 32'h7,
                                            32'hFFFF_FFF0, 32'h20, 32'h55};
    localparam logic [31:0] T_STR  [NV] = '{32'd1, 32'd3, 32'hFFFF_FFFE, 32'd0,
                                            32'd8, 32'd64, 32'd5};
    localparam int          T_LEN  [NV] = '{5, 130, 70, 64, 9, 12, 0};
    localparam bit          T_STL  [NV] = '{0, 0, 1, 0, 1, 0, 0};
    localparam bit          T_INJ  [NV] = '{0, 0, 0, 0, 0, 1, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [ADDR_W-1:0] cmd_stride = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              busy;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [VL_W-1:0]   req_vl;
    logic              done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    vec_agen u_vec_agen (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
        .cmd_stride(cmd_stride), .cmd_len(cmd_len), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_vl(req_vl), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int piece_len(input int len, input int k);
        int rem = len % MAX_VL;
        if (rem != 0 && k < rem) return rem;
        return MAX_VL;
    endfunction

    task automatic run_cmd(input logic [31:0] base, input logic [31:0] stride,
                           input int len, input bit stall, input bit inject);
        int idx = 0;
        int cyc = 0;
        logic [BANK_W-1:0] h_bank = '0;
        logic [ROW_W-1:0]  h_row = '0;
        logic [VL_W-1:0]   h_vl = '0;
        bit held = 0;
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_base   = base;
        cmd_stride = stride;
        cmd_len    = LEN_W'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (idx < len && cyc < 2000) begin
            logic [31:0] exp_a;
            req_ready = stall ? (cyc % 3 != 0) : 1'b1;
            // R10: a second command while busy must not disturb the sequence.
            if (inject && cyc == 2) begin
                cmd_valid = 1'b1; cmd_base = 32'hDEAD_0000; cmd_stride = 32'd7; cmd_len = 16'd3;
            end else begin
                cmd_valid = 1'b0;
            end
            #1;
            exp_a = base + 32'(idx) * stride;
            if (held) begin
                check(req_valid && req_bank == h_bank && req_row == h_row && req_vl == h_vl,
                      "R6 stall hold", {req_row, req_bank}, {h_row, h_bank});
                held = 0;
            end
            if (!stall)
                check(req_valid, "R7 no bubble", 32'(req_valid), 32'd1);
            check(!done, "R8 no early done", 32'(done), 32'd0);
            if (req_valid) begin
                check({req_row, req_bank} == exp_a,
                      inject ? "R10 sequence kept" : (idx == 0 ? "R2 base address" : "R3 stride step"),
                      {req_row, req_bank}, exp_a);
                check(req_bank == exp_a[BANK_W-1:0] && req_row == exp_a[ADDR_W-1:BANK_W],
                      "R2 bank/row split", 32'(req_bank), exp_a & 32'h3F);
                check(32'(req_vl) == 32'(piece_len(len, idx)), "R4 R5 piece length",
                      32'(req_vl), 32'(piece_len(len, idx)));
                if (req_ready) idx++;
                else begin
                    held = 1; h_bank = req_bank; h_row = req_row; h_vl = req_vl;
                end
            end
            cyc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        req_ready = 1'b0;
        #1;
        check(idx == len, "R8 request count", 32'(idx), 32'(len));
        check(done && !req_valid,
              (len == 0) ? "R9 zero length done" : "R8 done after last",
              {30'd0, done, req_valid}, 32'd2);
        @(negedge clk);
        #1;
        check(!done && !busy, "R8 done single pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!req_valid && !done && !busy, "R1 reset state",
              {29'd0, req_valid, done, busy}, 32'd0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++)
            run_cmd(T_BASE[v], T_STR[v], T_LEN[v], T_STL[v], T_INJ[v]);

        // R1: reset in the middle of a vector returns the block to idle.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = 32'h300; cmd_stride = 32'd1; cmd_len = 16'd40;
        req_ready = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(!req_valid && !done && !busy, "R1 reset mid-vector",
              {29'd0, req_valid, done, busy}, 32'd0);
        rst_n = 1'b1;
        req_ready = 1'b0;

        // R4: a length one above a full piece gives a 1-element piece first.
        run_cmd(32'h0, 32'd1, MAX_VL + 1, 1'b0, 1'b0);
        // R9: zero length directly after a finished vector.
        run_cmd(32'h10, 32'd2, 0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule